// File: doc/BRIEF.md
# Double-Buffered Memory-to-Memory DMA Channel

This block is one memory-to-memory copy channel. It has two descriptor slots. Each slot holds a source address, a destination address and a byte count. The channel copies one word at a time: it reads a word from the source and then writes that word to the destination. While one slot is being worked through, software can load the other slot. The channel then moves from the finished slot to the loaded slot with no gap between them.

Software uses a small register window with these registers:

- a control word holding the channel enable, the two interrupt enables and a self-clearing start bit;
- a pending-interrupt word;
- a status word that exposes the buffer-state machine and the transfer-control machine;
- per-slot byte count, source and destination registers.

Software should stop the channel only when the status word shows no buffer loaded and the control machine in stall. That state guarantees that no copy is still in flight.

Memory traffic uses a single word-wide request port. The channel raises a request and holds it until an acknowledge arrives. For a read, the data is captured in the acknowledge cycle.

Top module: `dmac_chan`

## Requirements
- R1: After reset the status word (offset 0x0C) reads 0, the pending word (offset 0x04) reads 0, `irq` is low and `mem_req` is low.
- R2: Writing a nonzero value to a free slot's byte count (slot 0 at 0x10, slot 1 at 0x14) loads that slot. The buffer-state field, status bits [5:4], goes none=0 → on=1 → next=2 as loaded slots go from zero to one to two.
- R3: Writes to the count, source (0x18/0x1C) or destination (0x20/0x24) register of a slot that is already loaded are ignored. A count write of zero is also ignored.
- R4: The control field, status bits [3:1], reads idle=0 while the channel enable (control bit 4) is clear. When enabled, the channel waits in stall=1 and issues no memory request until the start bit (control bit 0) has been written 1 and a loaded slot exists.
- R5: Each word is moved as a read of the source (memory-read=2) followed by a write of the same data to the destination (memory-write=3). A byte-count-wait=4 step follows, which advances both addresses by DATA_W/8 and lowers the count by the same amount.
- R6: When the current slot's count is used up and the other slot is loaded, the channel enters memory-read on the other slot in the very next cycle. It sets the next-buffer flag (pending bit 2), and the buffer state drops by one (next to on).
- R7: When the current slot finishes and the other slot is empty, the channel goes to buffer state none and control state stall. In the same cycle it sets the done flag (pending bit 1, mirrored in status bit 6) and clears the start request.
- R8: The done flag is never set while the control state is memory-read or memory-write. Launching a new transfer clears the done flag.
- R9: `irq` is the OR of the done flag ANDed with control bit 3 and the next-buffer flag ANDed with control bit 21. A flag whose enable is clear is still visible in the pending word.
- R10: A write to the pending word clears each flag whose bit is written 0 and leaves each flag whose bit is written 1.
- R11: Clearing the channel enable during a transfer lets the current word finish. The channel then goes idle with no further requests, and the slot keeps its remaining count.
- R12: Once raised, `mem_req`, together with its address, direction and write data, stays steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Register access strobe |
| cfg_we | input | 1 | Register write when set, read otherwise |
| cfg_addr | input | RAW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The bench checks that the status word exposes the exact buffer-state and control-state encodings at the moments that matter.

- **Slot switch.** At the first cycle the next-buffer flag is visible, the control state must already be memory-read. A design that stalled between slots, or that raised done at the slot switch, fails here.
- **Writes to a busy slot.** The bench rewrites a loaded slot's count and address and reads them back. A design that let software corrupt an in-flight descriptor fails here.
- **Flag masking and clearing.** The bench raises a flag while its enable is clear, then clears flags with mixed bit values. A design that confused the flag with its enable, or that cleared both flags on any write, fails here.
- **Disable mid-transfer.** The bench clears the enable in the middle of a transfer and checks that requests stop, that the partly used count is kept, and that the words already copied are intact. A design that dropped a word or ran on fails here.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        CTL_IDLE   = 3'd0,
        CTL_STALL  = 3'd1,
        CTL_MEMRD  = 3'd2,
        CTL_MEMWR  = 3'd3,
        CTL_BCWAIT = 3'd4
    } ctl_e;

    typedef enum logic [1:0] {
        BUF_NONE = 2'd0,
        BUF_ON   = 2'd1,
        BUF_NEXT = 2'd2
    } buf_e;

    // register byte offsets
    localparam logic [5:0] REG_CTRL = 6'h00;
    localparam logic [5:0] REG_PEND = 6'h04;
    localparam logic [5:0] REG_STAT = 6'h0C;
    localparam logic [5:0] REG_CNT0 = 6'h10;
    localparam logic [5:0] REG_SRC0 = 6'h18;
    localparam logic [5:0] REG_DST0 = 6'h20;

    // control word bits
    localparam int CB_START   = 0;
    localparam int CB_DONE_IE = 3;
    localparam int CB_EN      = 4;
    localparam int CB_NFB_IE  = 21;

    // pending word bits
    localparam int PB_DONE = 1;
    localparam int PB_NFB  = 2;

endpackage

// File: rtl/dmac_slot.sv
// One descriptor slot: addresses and byte count, locked while loaded.
module dmac_slot #(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int BPW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_src,
    input  logic          wr_dst,
    input  logic          wr_cnt,
    input  logic [31:0]   wdata,
    input  logic          step,
    output logic          load_ok,
    output logic          valid,
    output logic          last,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_STEP  = CW'(BPW);
    localparam logic [AW-1:0] ADDR_STEP = AW'(BPW);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        load_ok = wr_cnt && !s_q.valid && (wdata[CW-1:0] != '0);
        if (!s_q.valid && wr_src) s_d.src = wdata[AW-1:0];
        if (!s_q.valid && wr_dst) s_d.dst = wdata[AW-1:0];
        if (load_ok) begin
            s_d.valid = 1'b1;
            s_d.cnt   = wdata[CW-1:0];
        end
        if (step && s_q.valid) begin
            s_d.src = s_q.src + ADDR_STEP;
            s_d.dst = s_q.dst + ADDR_STEP;
            if (s_q.cnt <= CNT_STEP) begin
                s_d.cnt   = '0;
                s_d.valid = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.valid;
    assign last  = s_q.cnt <= CNT_STEP;
    assign src   = s_q.src;
    assign dst   = s_q.dst;
    assign cnt   = s_q.cnt;

endmodule

// File: rtl/dmac_mover.sv
// Transfer-control machine: walks the current slot word by word, swaps slots.
module dmac_mover
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               go,
    input  logic [1:0]         slot_valid,
    input  logic [1:0]         slot_load,
    input  logic [1:0]         slot_last,
    input  logic [1:0][AW-1:0] slot_src,
    input  logic [1:0][AW-1:0] slot_dst,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output ctl_e               ctl,
    output logic [1:0]         step,
    output logic               launch,
    output logic               done_evt,
    output logic               nfb_evt,
    output logic               mem_req,
    output logic               mem_wr,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata
);
    typedef struct packed {
        ctl_e          ctl;
        logic          cur;
        logic [DW-1:0] data;
    } mv_t;

    mv_t  m_d, m_q;
    logic oth;

    always_comb begin
        m_d       = m_q;
        oth       = ~m_q.cur;
        step      = '0;
        launch    = 1'b0;
        done_evt  = 1'b0;
        nfb_evt   = 1'b0;
        mem_req   = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = slot_src[m_q.cur];
        mem_wdata = m_q.data;
        unique case (m_q.ctl)
            CTL_IDLE: if (en) m_d.ctl = CTL_STALL;
            CTL_STALL: begin
                if (!en) begin
                    m_d.ctl = CTL_IDLE;
                end else if (go && slot_valid[m_q.cur]) begin
                    m_d.ctl = CTL_MEMRD;
                    launch  = 1'b1;
                end else if (go && slot_valid[oth]) begin
                    m_d.cur = oth;
                    m_d.ctl = CTL_MEMRD;
                    launch  = 1'b1;
                end
            end
            CTL_MEMRD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    m_d.data = mem_rdata;
                    m_d.ctl  = CTL_MEMWR;
                end
            end
            CTL_MEMWR: begin
                mem_req  = 1'b1;
                mem_wr   = 1'b1;
                mem_addr = slot_dst[m_q.cur];
                if (mem_ack) m_d.ctl = CTL_BCWAIT;
            end
            CTL_BCWAIT: begin
                step[m_q.cur] = 1'b1;
                if (slot_last[m_q.cur]) begin
                    m_d.cur = oth;
                    if (slot_valid[oth] || slot_load[oth]) begin
                        nfb_evt = 1'b1;
                        m_d.ctl = en ? CTL_MEMRD : CTL_IDLE;
                    end else begin
                        done_evt = 1'b1;
                        m_d.ctl  = en ? CTL_STALL : CTL_IDLE;
                    end
                end else begin
                    m_d.ctl = en ? CTL_MEMRD : CTL_IDLE;
                end
            end
            default: m_d.ctl = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{ctl: CTL_IDLE, cur: 1'b0, data: '0};
        else        m_q <= m_d;
    end

    assign ctl = m_q.ctl;

endmodule

// File: rtl/dmac_chan.sv
// Channel top: register window, buffer-state machine, interrupt flags.
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_sel,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [31:0]    cfg_wdata,
    output logic [31:0]    cfg_rdata,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);
    localparam int BPW = DW / 8;

    typedef struct packed {
        logic en;
        logic done_ie;
        logic nfb_ie;
        logic go;
        logic done_f;
        logic nfb_f;
        buf_e bstate;
    } chan_t;

    chan_t c_d, c_q;

    logic               wr;
    logic [1:0]         wr_src, wr_dst, wr_cnt;
    logic [1:0]         load_ok, slot_valid, slot_last, step;
    logic [1:0][AW-1:0] slot_src, slot_dst;
    logic [1:0][CW-1:0] slot_cnt;
    logic               launch, done_evt, nfb_evt, any_load, any_fin;
    ctl_e               ctl_st;
    buf_e               buf_st;
    logic               done_st;

    assign wr = cfg_sel && cfg_we;

    for (genvar i = 0; i < 2; i++) begin : g_slot
        localparam logic [5:0] A_CNT = REG_CNT0 + 6'(4 * i);
        localparam logic [5:0] A_SRC = REG_SRC0 + 6'(4 * i);
        localparam logic [5:0] A_DST = REG_DST0 + 6'(4 * i);
        assign wr_cnt[i] = wr && (cfg_addr == RAW'(A_CNT));
        assign wr_src[i] = wr && (cfg_addr == RAW'(A_SRC));
        assign wr_dst[i] = wr && (cfg_addr == RAW'(A_DST));
        dmac_slot #(.AW(AW), .CW(CW), .BPW(BPW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_src  (wr_src[i]),
            .wr_dst  (wr_dst[i]),
            .wr_cnt  (wr_cnt[i]),
            .wdata   (cfg_wdata),
            .step    (step[i]),
            .load_ok (load_ok[i]),
            .valid   (slot_valid[i]),
            .last    (slot_last[i]),
            .src     (slot_src[i]),
            .dst     (slot_dst[i]),
            .cnt     (slot_cnt[i])
        );
    end

    dmac_mover #(.AW(AW), .DW(DW)) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (c_q.en),
        .go         (c_q.go),
        .slot_valid (slot_valid),
        .slot_load  (load_ok),
        .slot_last  (slot_last),
        .slot_src   (slot_src),
        .slot_dst   (slot_dst),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .ctl        (ctl_st),
        .step       (step),
        .launch     (launch),
        .done_evt   (done_evt),
        .nfb_evt    (nfb_evt),
        .mem_req    (mem_req),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign any_load = |load_ok;
    assign any_fin  = |(step & slot_last & slot_valid);

    always_comb begin
        c_d = c_q;
        // control word
        if (done_evt) c_d.go = 1'b0;
        if (wr && cfg_addr == RAW'(REG_CTRL)) begin
            c_d.en      = cfg_wdata[CB_EN];
            c_d.done_ie = cfg_wdata[CB_DONE_IE];
            c_d.nfb_ie  = cfg_wdata[CB_NFB_IE];
            if (cfg_wdata[CB_START]) c_d.go = 1'b1;
        end
        // pending flags: write-zero clears, events win
        if (wr && cfg_addr == RAW'(REG_PEND)) begin
            c_d.done_f = c_q.done_f & cfg_wdata[PB_DONE];
            c_d.nfb_f  = c_q.nfb_f & cfg_wdata[PB_NFB];
        end
        if (launch)   c_d.done_f = 1'b0;
        if (done_evt) c_d.done_f = 1'b1;
        if (nfb_evt)  c_d.nfb_f  = 1'b1;
        // buffer-state machine
        unique case ({any_load, any_fin})
            2'b10: c_d.bstate = (c_q.bstate == BUF_NONE) ? BUF_ON : BUF_NEXT;
            2'b01: c_d.bstate = (c_q.bstate == BUF_NEXT) ? BUF_ON : BUF_NONE;
            default: c_d.bstate = c_q.bstate;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{en: 1'b0, done_ie: 1'b0, nfb_ie: 1'b0, go: 1'b0,
                             done_f: 1'b0, nfb_f: 1'b0, bstate: BUF_NONE};
        else        c_q <= c_d;
    end

    assign buf_st  = c_q.bstate;
    assign done_st = c_q.done_f;
    assign irq     = (c_q.done_f && c_q.done_ie) || (c_q.nfb_f && c_q.nfb_ie);

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            RAW'(REG_CTRL): begin
                cfg_rdata[CB_EN]      = c_q.en;
                cfg_rdata[CB_DONE_IE] = c_q.done_ie;
                cfg_rdata[CB_NFB_IE]  = c_q.nfb_ie;
            end
            RAW'(REG_PEND): begin
                cfg_rdata[PB_DONE] = c_q.done_f;
                cfg_rdata[PB_NFB]  = c_q.nfb_f;
            end
            RAW'(REG_STAT): cfg_rdata = {25'd0, c_q.done_f, c_q.bstate, ctl_st, 1'b0};
            RAW'(REG_CNT0):         cfg_rdata = 32'(slot_cnt[0]);
            RAW'(REG_CNT0 + 6'h4):  cfg_rdata = 32'(slot_cnt[1]);
            RAW'(REG_SRC0):         cfg_rdata = 32'(slot_src[0]);
            RAW'(REG_SRC0 + 6'h4):  cfg_rdata = 32'(slot_src[1]);
            RAW'(REG_DST0):         cfg_rdata = 32'(slot_dst[0]);
            RAW'(REG_DST0 + 6'h4):  cfg_rdata = 32'(slot_dst[1]);
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_wr,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input ctl_e          ctl_st,
    input buf_e          buf_st,
    input logic          done_st
);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)
                                   && (!mem_wr || $stable(mem_wdata))));

    assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_wr && mem_ack) |=> (mem_req && mem_wr));

    assert_no_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_st |-> (ctl_st != CTL_MEMRD && ctl_st != CTL_MEMWR));

    assert_busy_has_buf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == CTL_MEMRD || ctl_st == CTL_MEMWR) |-> (buf_st != BUF_NONE));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == CTL_IDLE || ctl_st == CTL_STALL) |-> !mem_req);

    assert_done_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_st) |-> (buf_st == BUF_NONE && ctl_st != CTL_MEMRD));

endmodule

bind dmac_chan dmac_chan_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_wr    (mem_wr),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ctl_st    (ctl_st),
    .buf_st    (buf_st),
    .done_st   (done_st)
);

// File: tb/dmac_chan_tb.sv
module dmac_chan_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, mem_req, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [64];

    int errors = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    dmac_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // one-cycle-latency memory responder
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:2]];
        end else mem_ack <= 1'b0;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_pend(input int bitpos, output logic [31:0] stat);
        logic [31:0] p;
        for (int n = 0; n < 500; n++) begin
            reg_rd(6'h04, p);
            if (p[bitpos]) begin
                reg_rd(6'h0C, stat);
                return;
            end
        end
        stat = '0;
        check(1'b0, "timeout waiting for flag", p, 32'(1 << bitpos));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(6'h0C, v); check(v == 0, "R1 status", v, 0);
        reg_rd(6'h04, v); check(v == 0, "R1 pending", v, 0);
        check(!irq && !mem_req, "R1 irq/req", {30'd0, irq, mem_req}, 0);
    endtask

    task automatic t_load_rules();
        logic [31:0] v;
        reg_wr(6'h10, 0);
        reg_rd(6'h0C, v); check(v[5:4] == 0, "R3 zero count ignored", v, 0);
        reg_wr(6'h18, 32'h00); reg_wr(6'h20, 32'h80); reg_wr(6'h10, 12);
        reg_rd(6'h0C, v); check(v[5:4] == 1, "R2 buf on after one load", v, 32'h10);
        reg_wr(6'h18, 32'h40);
        reg_rd(6'h18, v); check(v == 0, "R3 src write to loaded slot", v, 0);
        reg_wr(6'h10, 20);
        reg_rd(6'h10, v); check(v == 12, "R3 count write to loaded slot", v, 12);
    endtask

    task automatic t_no_start();
        logic [31:0] v;
        reg_wr(6'h00, 32'h18);
        repeat (5) @(negedge clk);
        reg_rd(6'h0C, v); check(v == 32'h12, "R4 enabled waits in stall", v, 32'h12);
        check(!mem_req, "R4 no request before start", {31'd0, mem_req}, 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        reg_wr(6'h00, 32'h19);
        wait_pend(1, v);
        check(v == 32'h42, "R7 status after last slot", v, 32'h42);
        for (int i = 0; i < 3; i++)
            check(mem[32 + i] == mem[i], "R5 copied word", mem[32 + i], mem[i]);
        reg_rd(6'h10, v); check(v == 0, "R5 count used up", v, 0);
        check(irq, "R9 irq with done enable", {31'd0, irq}, 1);
        reg_wr(6'h04, 32'h2);
        reg_rd(6'h04, v); check(v == 32'h2, "R10 written 1 keeps flag", v, 32'h2);
        reg_wr(6'h04, 32'h0);
        reg_rd(6'h04, v); check(v == 0, "R10 written 0 clears flag", v, 0);
        check(!irq, "R10 irq drops after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_pingpong();
        logic [31:0] v;
        reg_wr(6'h1C, 32'h10); reg_wr(6'h24, 32'hA0); reg_wr(6'h14, 8);
        reg_wr(6'h18, 32'h18); reg_wr(6'h20, 32'hA8); reg_wr(6'h10, 8);
        reg_rd(6'h0C, v); check(v[5:4] == 2, "R2 buf next with both loaded", v, 32'h20);
        reg_wr(6'h00, 32'h0020_0019);
        wait_pend(2, v);
        check(v[3:1] == 2, "R6 no idle cycle at slot switch", v, 32'h14);
        check(v[5:4] == 1, "R6 buf on after switch", v, 32'h14);
        check(v[6] == 0, "R6 no done at slot switch", v, 32'h14);
        check(irq, "R9 irq with next-buffer enable", {31'd0, irq}, 1);
        reg_wr(6'h04, 32'h2);
        reg_rd(6'h04, v); check(v == 0, "R10 next-buffer flag cleared", v, 0);
        wait_pend(1, v);
        check(v == 32'h42, "R7 status after second slot", v, 32'h42);
        for (int i = 0; i < 4; i++)
            check(mem[40 + i] == mem[4 + i], "R5 ping-pong word", mem[40 + i], mem[4 + i]);
        reg_wr(6'h04, 32'h0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        reg_wr(6'h1C, 32'h00); reg_wr(6'h24, 32'hC0); reg_wr(6'h14, 4);
        reg_wr(6'h00, 32'h11);
        wait_pend(1, v);
        check(!irq, "R9 masked done gives no irq", {31'd0, irq}, 0);
        reg_rd(6'h04, v); check(v == 32'h2, "R9 masked flag visible", v, 32'h2);
        check(mem[48] == mem[0], "R5 single word", mem[48], mem[0]);
        reg_wr(6'h04, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int moved;
        reg_wr(6'h18, 32'h00); reg_wr(6'h20, 32'hD0); reg_wr(6'h10, 40);
        reg_wr(6'h00, 32'h19);
        repeat (9) @(negedge clk);
        reg_wr(6'h00, 32'h08);
        repeat (12) @(negedge clk);
        reg_rd(6'h0C, v); check(v[3:1] == 0 && v[6] == 0, "R11 idle after disable", v, 32'h10);
        check(!mem_req, "R11 no request after disable", {31'd0, mem_req}, 0);
        reg_rd(6'h10, v);
        check(v != 0 && v < 40 && v[1:0] == 0, "R11 remaining count kept", v, 32'd40);
        moved = (40 - int'(v)) / 4;
        for (int i = 0; i < moved; i++)
            check(mem[52 + i] == mem[i], "R11 words before stop", mem[52 + i], mem[i]);
        check(mem[52 + moved] == 0, "R11 no word after stop", mem[52 + moved], 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = (i < 32) ? (32'h5A00_0000 + 32'(i) * 32'h0001_0101) : 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_rules();
        t_no_start();
        t_single();
        t_pingpong();
        t_masked();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule